// File: doc/BRIEF.md
# Run-Time Depth-Selectable Character FIFO

This block is a small first-in first-out buffer for 11-bit entries: a character of up to 9 bits plus two tag or status bits. It sits between a processor register interface and a serial engine. A transmit path and a receive path each use their own copy.

On the transmit side the processor pushes and the serial engine pops. On the receive side the engine pushes and the processor pops. There are four physical slots. The usable depth is chosen at run time, from one to four entries, and the full flag follows that chosen depth.

The block also keeps:
- an occupancy count;
- a threshold flag that a separate interrupt block can use to request service;
- a sticky overrun flag that records any push that was dropped.

Changing the depth setting empties the buffer, so that the pointers always agree with the new depth.

Top module: `flex_depth_fifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets synchronously. Afterwards `count` is 0, `empty` is 1, `full` is 0, `overrun` is 0 and `pop_data` is 0. The `depth_sel` value present during reset becomes the active depth, and no flush follows.
- R2: Entries leave in the order they were accepted. An accepted pop loads the oldest entry into the registered `pop_data` output, which shows it from the next clock edge onward.
- R3: `count` is the number of stored entries, from 0 to 4. An accepted push adds one and an accepted pop removes one.
- R4: The active depth is `depth_sel` + 1, so codes 0, 1, 2 and 3 give depths 1, 2, 3 and 4. `full` is 1 exactly when `count` equals the active depth. A push while `full` is 1 is dropped and leaves the stored contents unchanged, even if a pop happens in the same cycle.
- R5: `empty` is 1 exactly when `count` is 0. A pop while `empty` is 1 is ignored: `count` and `pop_data` keep their values.
- R6: A dropped push sets `overrun` from the next edge. `overrun` then stays 1 until reset or a depth-change flush.
- R7: `at_thresh` is 1 exactly when `count` is greater than or equal to `thresh`, compared as unsigned 3-bit numbers. The flag follows `thresh` within the same cycle.
- R8: A `depth_sel` value that differs from the active depth code flushes the buffer at the next edge. After that edge `count` is 0 and `overrun` is 0. A push or pop in the flush cycle is ignored, and `pop_data` keeps its value.
- R9: A push and a pop in the same cycle, with the buffer neither full nor empty, are both accepted and leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Write request for `push_data` |
| push_data | input | 11 | Entry to store |
| pop | input | 1 | Read request for the oldest entry |
| pop_data | output | 11 | Last entry popped (registered) |
| depth_sel | input | 2 | Active depth minus one; a change causes a flush |
| thresh | input | 3 | Occupancy level for the threshold flag |
| full | output | 1 | Occupancy equals the active depth |
| empty | output | 1 | No entries stored |
| at_thresh | output | 1 | Occupancy is at or above `thresh` |
| overrun | output | 1 | Sticky record of a dropped push |
| count | output | 3 | Number of stored entries |

## Verification
On every cycle, assertions check the following:
- `count` never exceeds the active depth;
- `full` and `empty` are never both 1;
- `overrun` stays set until a flush;
- a flush clears the count and the overrun flag;
- an accepted push and pop together leave the count unchanged;
- `pop_data` holds when no pop is accepted.

The first-in first-out order of the data can only be shown by the bench's reference queue, which compares every output on every cycle. The same applies to the exact values of the threshold flag under changing `thresh`, and to the effect of depth changes that arrive in the middle of traffic.

// File: rtl/flex_fifo_pkg.sv
// Package: flex_fifo_pkg
// Shared sizes and the operation encoding for the depth-selectable FIFO.
// Assumes the slot count is at least 2.
package flex_fifo_pkg;
    localparam int FF_DATA_W = 11;
    localparam int FF_SLOTS  = 4;

    // Net operation accepted in one cycle
    typedef enum logic [1:0] {
        FF_OP_IDLE = 2'b00,
        FF_OP_PUSH = 2'b01,
        FF_OP_POP  = 2'b10,
        FF_OP_BOTH = 2'b11
    } ff_op_e;
endpackage

// File: rtl/ff_flags.sv
// Module: ff_flags
// Derives the full, empty and threshold flags from the registered occupancy
// and the active depth code. Purely combinational.
// Assumes the active depth is depth_q + 1 and never exceeds SLOTS.
module ff_flags #(
    parameter int SLOTS = 4,
    localparam int SEL_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [SEL_W-1:0] depth_q,
    input  logic [CNT_W-1:0] thresh,
    output logic             full,
    output logic             empty,
    output logic             at_thresh
);
    logic [CNT_W-1:0] depth_lim;

    // Purpose: compare occupancy against the active depth, zero and threshold
    always_comb begin
        depth_lim = CNT_W'(depth_q) + CNT_W'(1);
        full      = (count == depth_lim);
        empty     = (count == '0);
        at_thresh = (count >= thresh);
    end

    // R5
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/ff_storage.sv
// Module: ff_storage
// Slot registers and the registered read port. Each slot has its own write
// enable. The read register loads only on an accepted pop and otherwise holds.
// Assumes the control logic never writes and reads the same slot in one cycle.
module ff_storage #(
    parameter int DATA_W = 11,
    parameter int SLOTS  = 4,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Purpose: capture pushed data into this slot when it is addressed
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(s))) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    // Purpose: registered read of the oldest slot on an accepted pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= slot_q[rd_ptr];
        end
    end

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/ff_ptrctl.sv
// Module: ff_ptrctl
// Pointer, occupancy, overrun and depth-tracking control. It accepts pushes
// and pops against the flags, wraps the pointers over the physical slots,
// and flushes when the depth code changes.
// Assumes full and empty come from ff_flags, driven by this block's count.
module ff_ptrctl
    import flex_fifo_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int SEL_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [SEL_W-1:0] depth_sel,
    input  logic             full,
    input  logic             empty,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic [SEL_W-1:0] depth_q,
    output logic             overrun
);
    logic   flush;
    ff_op_e op;

    // Purpose: decide flush and which requests are accepted this cycle
    always_comb begin
        flush = (depth_sel != depth_q);
        wr_en = push_req && !full && !flush;
        rd_en = pop_req && !empty && !flush;
        op    = ff_op_e'({rd_en, wr_en});
    end

    // Purpose: advance the pointers modulo the physical slot count
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Purpose: update pointers, occupancy, active depth and the overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            depth_q <= depth_sel;
            overrun <= 1'b0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            depth_q <= depth_sel;
            overrun <= 1'b0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            case (op)
                FF_OP_PUSH: count <= count + CNT_W'(1);
                FF_OP_POP:  count <= count - CNT_W'(1);
                default:    count <= count;
            endcase
            if (push_req && full) overrun <= 1'b1;
        end
    end

    // R4
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(depth_q) + CNT_W'(1));

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);

    // R6
    drop_sets_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !flush) |=> overrun);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !overrun);

    // R9
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> $stable(count));
endmodule

// File: rtl/flex_depth_fifo.sv
// Module: flex_depth_fifo
// Top of the run-time depth-selectable FIFO. It joins the storage, the
// pointer control and the flag logic. One copy serves one direction.
// Assumes depth_sel is code (depth - 1) and that thresh is meant in 1..SLOTS.
module flex_depth_fifo
    import flex_fifo_pkg::*;
#(
    parameter int DATA_W = FF_DATA_W,
    parameter int SLOTS  = FF_SLOTS,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int SEL_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [CNT_W-1:0]  thresh,
    output logic              full,
    output logic              empty,
    output logic              at_thresh,
    output logic              overrun,
    output logic [CNT_W-1:0]  count
);
    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [SEL_W-1:0] depth_q;

    ff_ptrctl #(.SLOTS(SLOTS)) i_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push),
        .pop_req  (pop),
        .depth_sel(depth_sel),
        .full     (full),
        .empty    (empty),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_en    (rd_en),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .depth_q  (depth_q),
        .overrun  (overrun)
    );

    ff_storage #(.DATA_W(DATA_W), .SLOTS(SLOTS)) i_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .wr_data(push_data),
        .rd_en  (rd_en),
        .rd_ptr (rd_ptr),
        .rd_data(pop_data)
    );

    ff_flags #(.SLOTS(SLOTS)) i_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .depth_q  (depth_q),
        .thresh   (thresh),
        .full     (full),
        .empty    (empty),
        .at_thresh(at_thresh)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !overrun && (pop_data == '0));
endmodule

// File: tb/test_flex_depth_fifo.sv
// Bench for flex_depth_fifo: a behavioural queue model, compared on every cycle.
module test_flex_depth_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [10:0] push_data = '0;
    logic        pop = 1'b0;
    logic [10:0] pop_data;
    logic [1:0]  depth_sel = 2'd3;
    logic [2:0]  thresh = 3'd1;
    logic        full, empty, at_thresh, overrun;
    logic [2:0]  count;

    int total = 0;
    int bad = 0;

    // Model state
    int        mq[$];
    int        m_pd = 0;
    bit        m_ovr = 0;
    int        m_dsel = 3;

    always #4 clk = ~clk;  // 125 MHz

    flex_depth_fifo i_flex_depth_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .depth_sel(depth_sel),
        .thresh(thresh), .full(full), .empty(empty),
        .at_thresh(at_thresh), .overrun(overrun), .count(count)
    );

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 pop_data", int'(pop_data), m_pd);
        chk("R3 count", int'(count), mq.size());
        chk("R4 full", int'(full), int'(mq.size() == m_dsel + 1));
        chk("R5 empty", int'(empty), int'(mq.size() == 0));
        chk("R6 overrun", int'(overrun), int'(m_ovr));
        chk("R7 at_thresh", int'(at_thresh), int'(mq.size() >= int'(thresh)));
    endtask

    // One cycle: drive at negedge, let the model follow the edge, compare at the next negedge
    task automatic step(bit ps, int d, bit pp, int ds, int th);
        bit pok, wok;
        push = ps; push_data = 11'(d); pop = pp;
        depth_sel = 2'(ds); thresh = 3'(th);
        @(posedge clk);
        if (ds != m_dsel) begin
            mq.delete(); m_ovr = 0; m_dsel = ds;
        end else begin
            wok = ps && (mq.size() < m_dsel + 1);
            pok = pp && (mq.size() > 0);
            if (ps && !wok) m_ovr = 1;
            if (pok) m_pd = mq.pop_front();
            if (wok) mq.push_back(d & 11'h7FF);
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 pop_data", int'(pop_data), 0);

        // R5 pop while empty is ignored
        step(0, 0, 1, 3, 1);
        chk("R5 pop empty count", int'(count), 0);
        // R3/R4 fill to depth 4, then push while full (R4, R6)
        for (int i = 0; i < 4; i++) step(1, 11'h100 + i, 0, 3, 4);
        chk("R4 full at depth 4", int'(full), 1);
        step(1, 11'h7AA, 0, 3, 4);
        chk("R6 overrun set", int'(overrun), 1);
        // R9 pop+push when full: the push is still dropped (R4)
        step(1, 11'h055, 1, 3, 2);
        // R2 drain in order
        for (int i = 0; i < 4; i++) step(0, 0, 1, 3, 2);
        chk("R6 overrun still set", int'(overrun), 1);
        // R9 simultaneous push and pop with one entry held
        step(1, 11'h011, 0, 3, 1);
        step(1, 11'h022, 1, 3, 1);
        chk("R9 count stable", int'(count), 1);
        chk("R2 first out", int'(pop_data), 11'h011);
        // R8 depth change flushes, ignores push, keeps pop_data and clears overrun
        step(1, 11'h033, 1, 0, 1);
        chk("R8 count flushed", int'(count), 0);
        chk("R8 overrun cleared", int'(overrun), 0);
        chk("R8 pop_data kept", int'(pop_data), 11'h011);
        // R4 depth 1: second push is dropped
        step(1, 11'h044, 0, 0, 1);
        chk("R4 full at depth 1", int'(full), 1);
        step(1, 11'h045, 0, 0, 0);
        chk("R7 thresh zero", int'(at_thresh), 1);
        step(0, 0, 1, 0, 5);
        chk("R2 depth1 data", int'(pop_data), 11'h044);
        // R7 threshold sweep at depth 3
        step(0, 0, 0, 2, 3);
        for (int i = 0; i < 3; i++) step(1, 11'h200 + i, 0, 2, 2);
        chk("R7 at_thresh 3>=2", int'(at_thresh), 1);

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            int ds;
            ds = ($urandom_range(0, 40) == 0) ? int'($urandom_range(0, 3)) : m_dsel;
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 2047)),
                 1'($urandom_range(0, 1)), ds, int'($urandom_range(0, 7)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule